// File: doc/BRIEF.md
# Floating-Point minNum Comparison Unit

This block is a purely combinational two-operand unit that returns the IEEE-754 minNum of two floating-point values. A 2-bit format code picks half, single or double precision. The operands arrive on 64-bit buses and only the low bits that belong to the selected format are used. The result comes back in the same low bits, and the bits above them are cleared.

In minNum, a quiet NaN stands for missing data, so a numeric operand always wins over it. Negative zero counts as strictly below positive zero. When the result must be a NaN, a default-NaN control decides between two outputs: a quieted copy of one of the input NaNs, or the canonical default NaN of the selected width. An invalid-operation flag reports signaling-NaN inputs. An alternate-handling input is present and has no effect on anything. A format code of 00 is not a legal encoding. For that code the unit raises an undefined-encoding output and does not produce a result.

Top module: `fpmin_unit`

## Requirements
- R1: The element width is 8 shifted left by `size_code`: 01 selects 16 bits, 10 selects 32 bits, 11 selects 64 bits. Operand bits above the element width are ignored. Result bits above the element width are 0.
- R2: When `size_code` is 00, `undef_enc` is 1, `result` is 0 and `invalid` is 0. For every other code `undef_enc` is 0.
- R3: When neither operand is a NaN and their sign bits (the top bit of the element) differ, the result is the operand with sign 1. So -0.0 against +0.0 in either order gives -0.0.
- R4: When neither operand is a NaN and the signs are equal, exponent and fraction are compared as one unsigned magnitude. With sign 0 the smaller magnitude wins, and with sign 1 the larger one wins. Infinities follow the same rule.
- R5: When exactly one operand is a quiet NaN (exponent all ones, fraction MSB 1) and the other is not a NaN, the result is the non-NaN operand.
- R6: If either operand is a signaling NaN (exponent all ones, fraction nonzero, fraction MSB 0), or both are NaNs, and `dn_mode` is 0, the result is a NaN picked in this order: operand A if it is signaling, else operand B if it is signaling, else operand A if it is a NaN, else operand B. The picked NaN is returned with its fraction MSB forced to 1.
- R7: In the same NaN case with `dn_mode` 1, the result is the default NaN of the selected width: sign 0, exponent all ones, fraction MSB 1 and all other fraction bits 0 (0x7E00, 0x7FC00000, 0x7FF8000000000000).
- R8: For a legal format code, `invalid` is 1 exactly when at least one operand is a signaling NaN within the selected width.
- R9: `alt_mode` has no effect. All outputs are identical for both of its values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First operand, element in the low bits |
| op_b | input | 64 | Second operand, element in the low bits |
| size_code | input | 2 | Format code: 01 half, 10 single, 11 double, 00 illegal |
| dn_mode | input | 1 | 1 returns the default NaN for NaN results |
| alt_mode | input | 1 | Alternate-handling control, accepted and ignored |
| result | output | 64 | minNum result, zero-extended |
| invalid | output | 1 | Invalid-operation flag (signaling NaN seen) |
| undef_enc | output | 1 | Illegal format code |

## Verification
The assertions sit inside the combinational processes. They assume that every input is a settled, known value whenever they are evaluated, so X and Z values never reach the classifiers. They also assume that the format code fixes which lane feeds the output.

The stimulus only drives 0 or 1 on every bit. It changes all inputs together once per cycle and samples half a cycle later. Random operands are drawn from a mix of zeros, infinities, quiet and signaling NaNs, and ordinary values. Random upper bits are added above the element, so that out-of-width bits are exercised without ever leaving the two-valued domain.

// File: rtl/fpmin_pkg.sv
package fpmin_pkg;

  typedef enum logic [1:0] {
    SZ_ILLEGAL = 2'b00,
    SZ_HALF    = 2'b01,
    SZ_SINGLE  = 2'b10,
    SZ_DOUBLE  = 2'b11
  } fp_size_e;

  localparam int unsigned NUM_FMT = 3;
  localparam int unsigned BUS_W   = 64;

  typedef struct packed {
    logic sign;
    logic nan;
    logic snan;
  } fp_class_t;

  function automatic int unsigned fmt_exp_w(int unsigned idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int unsigned fmt_frac_w(int unsigned idx);
    case (idx)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

endpackage

// File: rtl/fpmin_classify.sv
module fpmin_classify
  import fpmin_pkg::*;
#(
  parameter  int unsigned EXP_W  = 8,
  parameter  int unsigned FRAC_W = 23,
  localparam int unsigned W      = EXP_W + FRAC_W + 1
) (
  input  logic [W-1:0] val_i,
  output fp_class_t    cls_o,
  output logic [W-2:0] mag_o
);

  logic exp_ones;
  logic frac_nz;

  always_comb begin
    exp_ones   = &val_i[W-2:FRAC_W];
    frac_nz    = |val_i[FRAC_W-1:0];
    cls_o.sign = val_i[W-1];
    cls_o.nan  = exp_ones & frac_nz;
    cls_o.snan = exp_ones & frac_nz & ~val_i[FRAC_W-1];
    mag_o      = val_i[W-2:0];
    // R6/R8: a signaling NaN always has a payload below the quiet bit
    a_r8_snan_has_payload: assert (!cls_o.snan || |val_i[FRAC_W-2:0]);
  end

endmodule

// File: rtl/fpmin_lane.sv
module fpmin_lane
  import fpmin_pkg::*;
#(
  parameter  int unsigned EXP_W  = 8,
  parameter  int unsigned FRAC_W = 23,
  localparam int unsigned W      = EXP_W + FRAC_W + 1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         dn_mode_i,
  output logic [W-1:0] res_o,
  output logic         invalid_o
);

  localparam logic [W-1:0] DEF_NAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] QUIET_MASK = W'(1) << (FRAC_W - 1);

  fp_class_t    cls_a, cls_b;
  logic [W-2:0] mag_a, mag_b;
  logic         any_snan;
  logic         nan_out;
  logic         a_first;
  logic [W-1:0] nan_src;

  fpmin_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .val_i (a_i),
    .cls_o (cls_a),
    .mag_o (mag_a)
  );

  fpmin_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .val_i (b_i),
    .cls_o (cls_b),
    .mag_o (mag_b)
  );

  // NaN source priority and numeric ordering
  always_comb begin
    any_snan = cls_a.snan | cls_b.snan;
    nan_out  = any_snan | (cls_a.nan & cls_b.nan);

    if (cls_a.snan)      nan_src = a_i;
    else if (cls_b.snan) nan_src = b_i;
    else if (cls_a.nan)  nan_src = a_i;
    else                 nan_src = b_i;

    if (cls_a.sign != cls_b.sign) a_first = cls_a.sign;
    else if (cls_a.sign)          a_first = (mag_a >= mag_b);
    else                          a_first = (mag_a <= mag_b);
  end

  // result selection
  always_comb begin
    if (nan_out)        res_o = dn_mode_i ? DEF_NAN : (nan_src | QUIET_MASK);
    else if (cls_a.nan) res_o = b_i;
    else if (cls_b.nan) res_o = a_i;
    else                res_o = a_first ? a_i : b_i;
    invalid_o = any_snan;
  end

  // checks on the selected value against the operand classes
  always_comb begin
    if (!nan_out) begin
      a_r5_pick_operand: assert (res_o == a_i || res_o == b_i);
    end
    if (nan_out) begin
      a_r6_nan_is_quiet: assert (&res_o[W-2:FRAC_W] && res_o[FRAC_W-1]);
    end
    if (nan_out && dn_mode_i) begin
      a_r7_default_nan: assert (res_o == DEF_NAN);
    end
    if (!cls_a.nan && !cls_b.nan && (a_i[W-1] != b_i[W-1])) begin
      a_r3_negative_wins: assert (res_o[W-1]);
    end
    a_r8_flag_needs_nan: assert (!invalid_o || nan_out);
  end

endmodule

// File: rtl/fpmin_unit.sv
module fpmin_unit
  import fpmin_pkg::*;
(
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  input  logic [1:0]  size_code,
  input  logic        dn_mode,
  input  logic        alt_mode,
  output logic [63:0] result,
  output logic        invalid,
  output logic        undef_enc
);

  logic [BUS_W-1:0]   lane_res [NUM_FMT];
  logic [NUM_FMT-1:0] lane_inv;
  logic [NUM_FMT-1:0] lane_sel;
  logic               unused_alt;

  // alternate handling has no influence on minNum
  assign unused_alt = alt_mode;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int unsigned EW = fmt_exp_w(g);
    localparam int unsigned FW = fmt_frac_w(g);
    localparam int unsigned LW = EW + FW + 1;

    logic [LW-1:0] lane_r;
    logic          lane_i;

    fpmin_lane #(.EXP_W(EW), .FRAC_W(FW)) u_lane (
      .a_i       (op_a[LW-1:0]),
      .b_i       (op_b[LW-1:0]),
      .dn_mode_i (dn_mode),
      .res_o     (lane_r),
      .invalid_o (lane_i)
    );

    assign lane_res[g] = BUS_W'(lane_r);
    assign lane_inv[g] = lane_i;
  end

  always_comb begin
    for (int i = 0; i < NUM_FMT; i++) begin
      lane_sel[i] = (size_code == 2'(i + 1));
    end
  end

  always_comb begin
    result    = '0;
    invalid   = 1'b0;
    undef_enc = (size_code == SZ_ILLEGAL);
    for (int i = 0; i < NUM_FMT; i++) begin
      if (lane_sel[i]) begin
        result  = result | lane_res[i];
        invalid = invalid | lane_inv[i];
      end
    end
  end

  always_comb begin
    a_r1_one_lane: assert ($onehot0(lane_sel));
    if (undef_enc) begin
      a_r2_undef_silent: assert (result == '0 && !invalid && lane_sel == '0);
    end
    if (size_code == SZ_HALF) begin
      a_r1_half_upper_zero: assert (result[63:16] == '0);
    end
    if (size_code == SZ_SINGLE) begin
      a_r1_single_upper_zero: assert (result[63:32] == '0);
    end
  end

endmodule

// File: tb/fpmin_unit_bench.sv
module fpmin_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk;
  logic        rst_n;
  logic [63:0] op_a, op_b;
  logic [1:0]  size_code;
  logic        dn_mode, alt_mode;
  logic [63:0] result;
  logic        invalid, undef_enc;

  int n_checks = 0;
  int n_fails  = 0;

  fpmin_unit u_fpmin_unit (
    .op_a      (op_a),
    .op_b      (op_b),
    .size_code (size_code),
    .dn_mode   (dn_mode),
    .alt_mode  (alt_mode),
    .result    (result),
    .invalid   (invalid),
    .undef_enc (undef_enc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int fw_of(logic [1:0] sz);
    return (sz == 2'b01) ? 10 : (sz == 2'b10) ? 23 : 52;
  endfunction

  function automatic int ew_of(logic [1:0] sz);
    return (sz == 2'b01) ? 5 : (sz == 2'b10) ? 8 : 11;
  endfunction

  function automatic logic [63:0] wmask(logic [1:0] sz);
    int w = 8 << sz;
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic bit is_nan_m(logic [63:0] x, logic [1:0] sz);
    int f = fw_of(sz);
    int e = ew_of(sz);
    logic [63:0] ex = (x >> f) & ((64'd1 << e) - 64'd1);
    logic [63:0] fr = x & ((64'd1 << f) - 64'd1);
    return (ex == ((64'd1 << e) - 64'd1)) && (fr != 0);
  endfunction

  function automatic bit is_snan_m(logic [63:0] x, logic [1:0] sz);
    return is_nan_m(x, sz) && (((x >> (fw_of(sz) - 1)) & 64'd1) == 0);
  endfunction

  // total-order key: larger key means larger value, -0 below +0
  function automatic logic [63:0] order_key(logic [63:0] x, logic [1:0] sz);
    logic [63:0] sbit = 64'd1 << ((8 << sz) - 1);
    if ((x & sbit) != 0) return (~x) & wmask(sz);
    return x | sbit;
  endfunction

  function automatic logic [65:0] expect_out(logic [63:0] a_in, logic [63:0] b_in,
                                             logic [1:0] sz, logic dn);
    logic [63:0] a, b, r, dnan, qbit;
    bit an, bn, asn, bsn;
    int f;
    if (sz == 2'b00) return {64'd0, 1'b0, 1'b1};
    f    = fw_of(sz);
    a    = a_in & wmask(sz);
    b    = b_in & wmask(sz);
    an   = is_nan_m(a, sz);
    bn   = is_nan_m(b, sz);
    asn  = is_snan_m(a, sz);
    bsn  = is_snan_m(b, sz);
    qbit = 64'd1 << (f - 1);
    dnan = (((64'd1 << ew_of(sz)) - 64'd1) << f) | qbit;
    if (asn || bsn || (an && bn)) begin
      if (dn)       r = dnan;
      else if (asn) r = a | qbit;
      else if (bsn) r = b | qbit;
      else if (an)  r = a | qbit;
      else          r = b | qbit;
    end else if (an) r = b;
    else if (bn)     r = a;
    else             r = (order_key(a, sz) <= order_key(b, sz)) ? a : b;
    return {r, logic'(asn || bsn), 1'b0};
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                       input logic dn, input logic alt, input string tag);
    logic [65:0] exp_v;
    @(posedge clk);
    op_a      <= a;
    op_b      <= b;
    size_code <= sz;
    dn_mode   <= dn;
    alt_mode  <= alt;
    @(negedge clk);
    exp_v = expect_out(a, b, sz, dn);
    n_checks++;
    if ({result, invalid, undef_enc} !== exp_v) begin
      n_fails++;
      $display("FAIL %s: a=%h b=%h sz=%b dn=%b alt=%b actual res=%h inv=%b und=%b expected res=%h inv=%b und=%b",
               tag, a, b, sz, dn, alt, result, invalid, undef_enc,
               exp_v[65:2], exp_v[1], exp_v[0]);
    end
  endtask

  function automatic logic [63:0] gen_operand(logic [1:0] sz);
    int w = 8 << sz;
    int f = fw_of(sz);
    int e = ew_of(sz);
    logic [63:0] rnd  = {$urandom(), $urandom()};
    logic [63:0] sgn  = 64'($urandom() & 1) << (w - 1);
    logic [63:0] emax = ((64'd1 << e) - 64'd1) << f;
    logic [63:0] fr   = rnd & ((64'd1 << (f - 1)) - 64'd1);
    logic [63:0] qbit = 64'd1 << (f - 1);
    logic [63:0] v;
    case ($urandom() % 8)
      0:       v = sgn;
      1:       v = sgn | emax;
      2:       v = sgn | emax | qbit | fr;
      3:       v = sgn | emax | ((fr == 0) ? 64'd1 : fr);
      4:       v = sgn | (64'd1 << f) | fr;
      default: v = rnd & wmask(sz);
    endcase
    return (v & wmask(sz)) | ({$urandom(), $urandom()} & ~wmask(sz));
  endfunction

  // watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n     = 1'b0;
    op_a      = '0;
    op_b      = '0;
    size_code = 2'b00;
    dn_mode   = 1'b0;
    alt_mode  = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R2: idle state with illegal code
    apply(64'h0, 64'h0, 2'b00, 1'b0, 1'b0, "R2 initial illegal");
    apply(64'h7D00, 64'h7C01, 2'b00, 1'b0, 1'b0, "R2 illegal with sNaN");
    // R3
    apply(64'h8000_0000, 64'h0000_0000, 2'b10, 1'b0, 1'b0, "R3 -0 vs +0");
    apply(64'h0000_0000, 64'h8000_0000, 2'b10, 1'b0, 1'b0, "R3 +0 vs -0");
    apply(64'h3FF0_0000_0000_0000, 64'hC000_0000_0000_0000, 2'b11, 1'b0, 1'b0, "R3 1 vs -2");
    // R4
    apply(64'hBF80_0000, 64'hC000_0000, 2'b10, 1'b0, 1'b0, "R4 -1 vs -2");
    apply(64'h4200, 64'h3C00, 2'b01, 1'b0, 1'b0, "R4 3 vs 1");
    apply(64'h7C00, 64'h4500, 2'b01, 1'b0, 1'b0, "R4 +inf vs 5");
    apply(64'hC500, 64'hFC00, 2'b01, 1'b0, 1'b0, "R4 -5 vs -inf");
    // R5
    apply(64'h7E01, 64'h3C00, 2'b01, 1'b0, 1'b0, "R5 qNaN first");
    apply(64'hBC00, 64'hFE01, 2'b01, 1'b0, 1'b0, "R5 qNaN second");
    // R6, R8
    apply(64'h7D00, 64'h3C00, 2'b01, 1'b0, 1'b0, "R6 R8 sNaN quieted");
    apply(64'h7E05, 64'hFE07, 2'b01, 1'b0, 1'b0, "R6 both qNaN keep A");
    apply(64'h7E05, 64'h7C01, 2'b01, 1'b0, 1'b0, "R6 R8 sNaN B beats qNaN A");
    apply(64'h7FF0_0000_0000_0001, 64'h7FA0_0000_0000_0000, 2'b11, 1'b0, 1'b0, "R6 R8 double sNaN A");
    // R7
    apply(64'h7E05, 64'h7C01, 2'b01, 1'b1, 1'b0, "R7 half default");
    apply(64'h7F80_0001, 64'h3F80_0000, 2'b10, 1'b1, 1'b0, "R7 single default");
    apply(64'hFFF8_0000_0000_0001, 64'h7FF8_0000_0000_0002, 2'b11, 1'b1, 1'b0, "R7 double default");
    // R1
    apply(64'hDEAD_BEEF_0000_3C00, 64'h1234_5678_0000_4000, 2'b01, 1'b0, 1'b0, "R1 half upper ignored");
    apply(64'hFFFF_FFFF_3F80_0000, 64'h0000_0001_4000_0000, 2'b10, 1'b0, 1'b0, "R1 single upper ignored");
    apply(64'h0000_0000_7D00_0000, 64'h0000_0000_0000_7D00, 2'b11, 1'b0, 1'b0, "R1 R8 double no NaN");
    // R9
    apply(64'h7D00, 64'h3C00, 2'b01, 1'b0, 1'b1, "R9 alt set sNaN");
    apply(64'h8000, 64'h0000, 2'b01, 1'b0, 1'b1, "R9 alt set zeros");

    for (int i = 0; i < N_RANDOM; i++) begin
      logic [1:0]  sz = 2'($urandom() % 4);
      logic [63:0] a  = gen_operand((sz == 2'b00) ? 2'b01 : sz);
      logic [63:0] b  = gen_operand((sz == 2'b00) ? 2'b01 : sz);
      logic        dn = 1'($urandom() & 1);
      apply(a, b, sz, dn, 1'b0, "R1 R3 R4 R5 R6 R7 R8 random");
      apply(a, b, sz, dn, 1'b1, "R9 random alt");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule